// File: doc/BRIEF.md
# Three-State Power Mode Controller

This block tracks the power mode of a small system-on-chip and holds it in one of three states: Operating, Idle and Standby. Software enters a low-power state by writing to one of two decoded addresses. A write that hits the halt address stops the CPU clock and leaves every peripheral and the main clock source running. A write that hits the standby address drops the system into Standby, where RUN goes low and a DRAM self-refresh request is raised.

A pending interrupt, or a rising edge on the asynchronous wakeup pin, brings the controller back to Operating from either low-power state. A power-fail indication or a user reset forces Standby with no help from software. Either one overrides every wake source. Power-on reset is the active-low asynchronous reset of the block and also lands in Standby.

All outputs come from flops that update on the clock edge. The CPU clock enable therefore changes only on a cycle boundary and cannot cut a clock pulse short.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_ni is low, the state is Standby at once, without a clock edge. In that state cpu_clk_en_o=0, run_o=0, clk_keep_o=0 and refresh_req_o=1.
- R2: State encoding on mode_o: Operating=0, Idle=1, Standby=2. In Operating, a cycle with wr_i=1 and halt_hit_i=1 moves the state to Idle at the next edge, provided irq_i=0, pwr_fail_i=0, usr_rst_i=0 and stby_hit_i=0.
- R3: In Operating, a cycle with wr_i=1 and stby_hit_i=1 moves the state to Standby at the next edge. This also happens when halt_hit_i=1 in the same cycle or irq_i=1.
- R4: In any state, pwr_fail_i=1 or usr_rst_i=1 gives Standby at the next edge. This overrides irq_i and any wakeup edge.
- R5: From Idle or Standby, irq_i=1 gives Operating at the next edge, unless R4 applies.
- R6: wake_i is synchronised through two flops. A low-to-high change of wake_i that is set up before edge k moves the state from Idle or Standby to Operating at edge k+2. A level that stays high triggers no further wakeup.
- R7: In Operating, a halt write in the same cycle as irq_i=1 is not taken, and the state stays Operating.
- R8: cpu_clk_en_o is 1 exactly while the state is Operating. run_o and clk_keep_o are 1 in Operating and Idle. refresh_req_o is 1 in Standby. All of them change only at a clock edge, together with mode_o.
- R9: halt_hit_i or stby_hit_i without wr_i has no effect. A halt or standby write while in Idle or Standby also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| wr_i | input | 1 | CPU write strobe |
| halt_hit_i | input | 1 | Write address decodes to the halt location |
| stby_hit_i | input | 1 | Write address decodes to the standby location |
| irq_i | input | 1 | Pending interrupt flag |
| wake_i | input | 1 | Asynchronous wakeup pin |
| pwr_fail_i | input | 1 | Power-fail indication |
| usr_rst_i | input | 1 | User reset request |
| mode_o | output | 2 | Current state (0 Operating, 1 Idle, 2 Standby) |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| run_o | output | 1 | High outside Standby |
| clk_keep_o | output | 1 | Keep the main clock source running |
| refresh_req_o | output | 1 | DRAM self-refresh request |

## Verification
The bench targets five corner cases, each tied to a typical design error:
- Wakeup latency: it checks that the state is still Idle one cycle before the predicted edge and is Operating at that edge. A synchroniser that is too short or too long is caught there.
- Held wakeup level: it holds wake_i high and halts again. An edge detector that reacts to the level would fall straight back to Operating.
- Same-cycle conflicts: it drives halt with interrupt, halt with standby, and interrupt or wakeup with power fail. Any of these conflicts resolved the wrong way shows up as the wrong next state.
- Ignored writes: it applies writes outside Operating and hits without a strobe, which a loose decoder would act on.
- Asynchronous reset: it drops rst_ni mid-cycle and samples before the next edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_OPER = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_STBY = 2'd2
  } pmc_mode_e;
endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], wake_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  logic      halt_hit_i,
  input  logic      stby_hit_i,
  input  logic      irq_i,
  input  logic      wake_rise_i,
  input  logic      pwr_fail_i,
  input  logic      usr_rst_i,
  output pmc_mode_e mode_d_o,
  output pmc_mode_e mode_q_o
);
  pmc_mode_e mode_q, mode_d;
  logic      force_stby, wake_evt, halt_wr, stby_wr;

  assign force_stby = pwr_fail_i | usr_rst_i;
  assign wake_evt   = irq_i | wake_rise_i;
  assign halt_wr    = wr_i & halt_hit_i;
  assign stby_wr    = wr_i & stby_hit_i;

  always_comb begin
    mode_d = mode_q;
    if (force_stby) begin
      mode_d = MODE_STBY;
    end else begin
      unique case (mode_q)
        MODE_OPER: begin
          if (stby_wr)                mode_d = MODE_STBY;
          else if (halt_wr && !irq_i) mode_d = MODE_IDLE;
        end
        MODE_IDLE, MODE_STBY: begin
          if (wake_evt) mode_d = MODE_OPER;
        end
        default: mode_d = MODE_STBY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_STBY;
    else         mode_q <= mode_d;
  end

  assign mode_d_o = mode_d;
  assign mode_q_o = mode_q;
endmodule

// File: rtl/pmc_out_regs.sv
module pmc_out_regs
  import pmc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pmc_mode_e mode_d_i,
  output logic      cpu_clk_en_o,
  output logic      run_o,
  output logic      clk_keep_o,
  output logic      refresh_req_o
);
  // registered from next state so edges line up with the mode register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_clk_en_o  <= 1'b0;
      run_o         <= 1'b0;
      clk_keep_o    <= 1'b0;
      refresh_req_o <= 1'b1;
    end else begin
      cpu_clk_en_o  <= (mode_d_i == MODE_OPER);
      run_o         <= (mode_d_i != MODE_STBY);
      clk_keep_o    <= (mode_d_i != MODE_STBY);
      refresh_req_o <= (mode_d_i == MODE_STBY);
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       halt_hit_i,
  input  logic       stby_hit_i,
  input  logic       irq_i,
  input  logic       wake_i,
  input  logic       pwr_fail_i,
  input  logic       usr_rst_i,
  output logic [1:0] mode_o,
  output logic       cpu_clk_en_o,
  output logic       run_o,
  output logic       clk_keep_o,
  output logic       refresh_req_o
);
  logic      wake_rise;
  pmc_mode_e mode_d, mode_q;

  pmc_wake_sync #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wake_i (wake_i),
    .rise_o (wake_rise)
  );

  pmc_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .halt_hit_i  (halt_hit_i),
    .stby_hit_i  (stby_hit_i),
    .irq_i       (irq_i),
    .wake_rise_i (wake_rise),
    .pwr_fail_i  (pwr_fail_i),
    .usr_rst_i   (usr_rst_i),
    .mode_d_o    (mode_d),
    .mode_q_o    (mode_q)
  );

  pmc_out_regs u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_d_i      (mode_d),
    .cpu_clk_en_o  (cpu_clk_en_o),
    .run_o         (run_o),
    .clk_keep_o    (clk_keep_o),
    .refresh_req_o (refresh_req_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       halt_hit_i,
  input logic       stby_hit_i,
  input logic       irq_i,
  input logic       pwr_fail_i,
  input logic       usr_rst_i,
  input logic [1:0] mode_o,
  input logic       cpu_clk_en_o,
  input logic       run_o,
  input logic       clk_keep_o,
  input logic       refresh_req_o
);
  logic quiet;
  assign quiet = !pwr_fail_i && !usr_rst_i;

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3); // R2
  AST_HALT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && wr_i && halt_hit_i && !stby_hit_i && !irq_i && quiet) |=> mode_o == 2'd1); // R2
  AST_STBY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && wr_i && stby_hit_i && quiet) |=> mode_o == 2'd2); // R3
  AST_FORCE_STBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_fail_i || usr_rst_i) |=> mode_o == 2'd2); // R4
  AST_IRQ_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0 && irq_i && quiet) |=> mode_o == 2'd0); // R5
  AST_IRQ_BLOCKS_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && irq_i && !(wr_i && stby_hit_i) && quiet) |=> mode_o == 2'd0); // R7
  AST_CLK_EN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o == (mode_o == 2'd0)); // R8
  AST_RUN_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o == (mode_o != 2'd2)) && (clk_keep_o == run_o) && (refresh_req_o == !run_o)); // R8
  AST_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && !wr_i && !irq_i && quiet) |=> mode_o == 2'd0); // R9
  AST_CLK_EN_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_clk_en_o) |-> $rose(run_o) || $past(run_o)); // R8
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_i          (wr_i),
  .halt_hit_i    (halt_hit_i),
  .stby_hit_i    (stby_hit_i),
  .irq_i         (irq_i),
  .pwr_fail_i    (pwr_fail_i),
  .usr_rst_i     (usr_rst_i),
  .mode_o        (mode_o),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .run_o         (run_o),
  .clk_keep_o    (clk_keep_o),
  .refresh_req_o (refresh_req_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] OPER = 2'd0, IDLE = 2'd1, STBY = 2'd2;
  localparam int NVEC = 19;
  // {wr, halt, stby, irq, pwr_fail, usr_rst, expected_mode[1:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b000100_00, // R5 standby->oper
    8'b000000_00, // hold
    8'b010000_00, // R9 hit without strobe
    8'b110000_01, // R2 halt
    8'b101000_01, // R9 standby write in idle
    8'b000100_00, // R5 idle->oper
    8'b110100_00, // R7 irq beats halt
    8'b111000_10, // R3 standby beats halt
    8'b110000_10, // R9 halt write in standby
    8'b000100_00, // R5
    8'b101000_10, // R3 standby write
    8'b000110_10, // R4 pwr fail beats irq
    8'b000101_10, // R4 user reset beats irq
    8'b000100_00, // R5
    8'b000001_10, // R4 user reset from oper
    8'b000100_00, // R5
    8'b110000_01, // R2
    8'b000010_10, // R4 pwr fail from idle
    8'b000100_00  // R5
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_i = 0, halt_hit_i = 0, stby_hit_i = 0, irq_i = 0, wake_i = 0;
  logic pwr_fail_i = 0, usr_rst_i = 0;
  logic [1:0] mode_o;
  logic cpu_clk_en_o, run_o, clk_keep_o, refresh_req_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .halt_hit_i(halt_hit_i),
    .stby_hit_i(stby_hit_i), .irq_i(irq_i), .wake_i(wake_i),
    .pwr_fail_i(pwr_fail_i), .usr_rst_i(usr_rst_i), .mode_o(mode_o),
    .cpu_clk_en_o(cpu_clk_en_o), .run_o(run_o), .clk_keep_o(clk_keep_o),
    .refresh_req_o(refresh_req_o)
  );

  task automatic check_mode(string req, logic [1:0] exp);
    logic [3:0] act_o, exp_o;
    n_run++;
    act_o = {cpu_clk_en_o, run_o, clk_keep_o, refresh_req_o};
    exp_o = {exp == OPER, exp != STBY, exp != STBY, exp == STBY};
    if (mode_o !== exp || act_o !== exp_o) begin
      n_fail++;
      $display("FAIL %s: mode=%0d outs=%b expected mode=%0d outs=%b",
               req, mode_o, act_o, exp, exp_o);
    end
  endtask

  task automatic drive(logic [5:0] v);
    {wr_i, halt_hit_i, stby_hit_i, irq_i, pwr_fail_i, usr_rst_i} = v;
  endtask

  task automatic step(logic [5:0] v);
    drive(v);
    @(posedge clk);
    @(negedge clk);
    drive(6'b0);
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    check_mode("R1 reset state", STBY);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_mode("R1 after release", STBY);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][7:2]);
      check_mode($sformatf("R2/R3/R4/R5/R7/R9 vec %0d", i), VEC[i][1:0]);
    end

    // R6 wakeup latency from Idle
    step(6'b110000);
    check_mode("R6 setup idle", IDLE);
    wake_i = 1'b1;
    cycles(2);
    check_mode("R6 not yet awake", IDLE);
    cycles(1);
    check_mode("R6 woke at k+2", OPER);
    // R6 held level does not retrigger
    step(6'b110000);
    cycles(4);
    check_mode("R6 held level ignored", IDLE);
    wake_i = 1'b0;
    cycles(3);
    check_mode("R6 low level no effect", IDLE);
    // R6 from Standby
    irq_i = 1'b1;
    cycles(1);
    irq_i = 1'b0;
    step(6'b101000);
    check_mode("R3 setup standby", STBY);
    wake_i = 1'b1;
    cycles(3);
    check_mode("R6 standby wake", OPER);
    wake_i = 1'b0;
    // R4 wake edge with power fail
    step(6'b101000);
    cycles(2);
    wake_i = 1'b1;
    pwr_fail_i = 1'b1;
    cycles(3);
    pwr_fail_i = 1'b0;
    check_mode("R4 wake overridden", STBY);
    wake_i = 1'b0;
    cycles(3);
    check_mode("R4 stays standby", STBY);
    // R1 asynchronous reset mid-cycle
    step(6'b000100);
    check_mode("R5 before reset", OPER);
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    check_mode("R1 async reset", STBY);
    @(negedge clk);
    rst_ni = 1'b1;
    cycles(1);
    check_mode("R1 after second release", STBY);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule